// File: doc/BRIEF.md
# Packet Byte DMA Handshake Controller

This block hands a 22-byte corrected payload to a host DMA engine one byte at a time. When DMA mode is on, it raises a request for the next byte. The host answers with a strobe. That strobe is either the ordinary read access (chip-select low, read low, address 0) or a separate acknowledge pin, and a configuration bit picks which one. While the strobe is held, the controller drops the request and drives the byte on an 8-bit bus. After the strobe is released, the controller advances its byte pointer. It then holds the request off for a programmable number of clock cycles before it asks again.

Each of the request and acknowledge pins can have its active level inverted. The payload comes from a byte-read source: the block presents an address and reads the byte back in the same cycle. After the last byte of a packet the block stays silent until a new packet is loaded.

When DMA mode is off, the same read access still pulls bytes in order from the pointer, so a packet can be finished in register mode. The 16-bit bus setting is illegal in DMA mode, and the controller refuses to request while it is set.

Top module: `pkt_dma_ctrl`

## Requirements
- R1: After reset the request is inactive, `dataOe` is 0, `srcAddr` is 0 and the inter-request gap count is 4.
- R2: The request is active only while `cfgDmaEn` is 1, `cfgBusWide` is 0 and bytes remain in the packet. Clearing `cfgDmaEn` makes the request inactive in the same cycle, without waiting for a clock edge, and leaves `srcAddr` unchanged.
- R3: With `cfgAckSel`=0, the strobe is `hostCsN`=0, `hostRdN`=0 and `hostAddr`=0 while the request is active. From the next clock edge the request is inactive, `dataOe` is 1 and `dataOut` holds the source byte at `srcAddr`, stable until the strobe is released. The clock edge that samples the release increments `srcAddr`.
- R4: With `cfgAckSel`=1, the acknowledge pin is the only DMA strobe. A read access during an active request has no effect.
- R5: After a DMA strobe is released, the request stays inactive for exactly max(G,1) cycles before it returns, where G is the programmed gap count.
- R6: A cycle with `gapWr`=1 loads `gapWrData` as the new gap count G.
- R7: With `cfgReqInv`=0 the request pin is active low. With `cfgReqInv`=1 it is active high.
- R8: Once the byte at index 21 has been transferred (`srcAddr`=22), no request is issued. A `pktLoad` pulse sets `srcAddr` to 0, ends any request, and lets requests start again.
- R9: With `cfgDmaEn`=1 and `cfgBusWide`=1 (the illegal 16-bit setting) no request is issued.
- R10: With `cfgDmaEn`=0, a read access at `hostAddr`=0 delivers the byte at the pointer and advances it. A read access at any other address is ignored.
- R11: With `cfgAckInv`=0 the acknowledge pin is active low. With `cfgAckInv`=1 it is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgDmaEn | input | 1 | DMA mode enable (control bit 0) |
| cfgAckSel | input | 1 | Use acknowledge pin as strobe (control bit 1) |
| cfgReqInv | input | 1 | Invert request pin level (control bit 4) |
| cfgAckInv | input | 1 | Invert acknowledge pin level (control bit 5) |
| cfgBusWide | input | 1 | 16-bit bus setting; illegal in DMA mode |
| gapWr | input | 1 | Load a new gap count |
| gapWrData | input | 8 | Gap count in clock cycles |
| pktLoad | input | 1 | New packet available; restart pointer |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostAddr | input | 4 | Host register address |
| hostAck | input | 1 | Host DMA acknowledge pin |
| dmaReq | output | 1 | DMA request pin |
| dataOut | output | 8 | Byte on the host bus |
| dataOe | output | 1 | Host bus output enable |
| srcAddr | output | 5 | Byte index into the payload source |
| srcData | input | 8 | Payload byte at `srcAddr` |

## Verification
On every cycle the assertions check several properties. A request never stands while DMA mode is off, while the bus is wide, while the packet is exhausted or while a byte is on the bus. The byte stays stable while it is driven, and the request is always off in the cycle after the bus is released. The bench scenarios are needed for the rest. They show the exact gap length for several programmed counts, the choice between read strobe and acknowledge, the effect of both polarity bits, the byte order across a full packet, and register-mode reads that continue from the point where DMA was switched off.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ptrClr;
    logic ptrInc;
    logic dataLoad;
    logic gapLoad;
    logic gapDec;
  } ctrl_strb_t;

endpackage

// File: rtl/pkt_dma_path.sv
module pkt_dma_path
  import pkt_dma_pkg::*;
#(
  parameter int PKT_BYTES = 22,
  parameter int GAP_W     = 8,
  parameter int GAP_RESET = 4,
  parameter int DATA_W    = 8,
  localparam int PTR_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strb_t        strb,
  input  logic              gapWr,
  input  logic [GAP_W-1:0]  gapWrData,
  input  logic [DATA_W-1:0] srcData,
  output logic [PTR_W-1:0]  srcAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              ptrLast,
  output logic              ptrEnd,
  output logic              gapDone
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(PKT_BYTES - 1);
  localparam logic [PTR_W-1:0] END_IDX  = PTR_W'(PKT_BYTES);
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(GAP_RESET);

  logic [PTR_W-1:0]  bytePtr;
  logic [DATA_W-1:0] dataReg;
  logic [GAP_W-1:0]  gapReg;
  logic [GAP_W-1:0]  gapCnt;

  // byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytePtr <= '0;
    end else if (strb.ptrClr) begin
      bytePtr <= '0;
    end else if (strb.ptrInc && (bytePtr != END_IDX)) begin
      bytePtr <= bytePtr + 1'b1;
    end
  end

  // captured byte held on the bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
    end else if (strb.dataLoad) begin
      dataReg <= srcData;
    end
  end

  // programmed gap count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapReg <= GAP_INIT;
    end else if (gapWr) begin
      gapReg <= gapWrData;
    end
  end

  // running gap counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strb.gapLoad) begin
      gapCnt <= gapReg;
    end else if (strb.gapDec && (gapCnt != '0)) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign srcAddr = bytePtr;
  assign dataOut = dataReg;
  assign ptrLast = (bytePtr == LAST_IDX);
  assign ptrEnd  = (bytePtr == END_IDX);
  assign gapDone = (gapCnt <= GAP_W'(1));

endmodule

// File: rtl/pkt_dma_fsm.sv
module pkt_dma_fsm
  import pkt_dma_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgDmaEn,
  input  logic              cfgAckSel,
  input  logic              cfgAckInv,
  input  logic              cfgBusWide,
  input  logic              pktLoad,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostAck,
  input  logic              ptrLast,
  input  logic              ptrEnd,
  input  logic              gapDone,
  output ctrl_strb_t        strb,
  output logic              reqActive,
  output logic              busDrive
);

  dma_state_e state, stateNxt;
  logic viaAck, viaAckNxt;

  logic dmaOk;
  logic rdStrb;
  logic ackStrb;
  logic dmaStrb;
  logic heldStrb;

  assign dmaOk    = cfgDmaEn && !cfgBusWide;
  assign rdStrb   = !hostCsN && !hostRdN && (hostAddr == '0);
  assign ackStrb  = (hostAck == cfgAckInv);
  assign dmaStrb  = cfgAckSel ? ackStrb : rdStrb;
  assign heldStrb = viaAck ? ackStrb : rdStrb;

  always_comb begin
    stateNxt = state;
    viaAckNxt = viaAck;
    strb = '0;
    if (pktLoad) begin
      strb.ptrClr = 1'b1;
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!ptrEnd) begin
            if (dmaOk) begin
              stateNxt = ST_REQ;
            end else if (!cfgDmaEn && rdStrb) begin
              stateNxt = ST_XFER;
              viaAckNxt = 1'b0;
              strb.dataLoad = 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (!dmaOk) begin
            stateNxt = ST_IDLE;
          end else if (dmaStrb) begin
            stateNxt = ST_XFER;
            viaAckNxt = cfgAckSel;
            strb.dataLoad = 1'b1;
          end
        end
        ST_XFER: begin
          if (!heldStrb) begin
            strb.ptrInc = 1'b1;
            if (dmaOk && !ptrLast) begin
              stateNxt = ST_GAP;
              strb.gapLoad = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (!dmaOk) begin
            stateNxt = ST_IDLE;
          end else if (gapDone) begin
            stateNxt = ST_REQ;
          end else begin
            strb.gapDec = 1'b1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      viaAck <= 1'b0;
    end else begin
      state  <= stateNxt;
      viaAck <= viaAckNxt;
    end
  end

  // request is gated combinationally so a disable takes effect at once
  assign reqActive = (state == ST_REQ) && dmaOk && !ptrEnd;
  assign busDrive  = (state == ST_XFER);

endmodule

// File: rtl/pkt_dma_ctrl.sv
module pkt_dma_ctrl
  import pkt_dma_pkg::*;
#(
  parameter int PKT_BYTES = 22,
  parameter int GAP_W     = 8,
  parameter int GAP_RESET = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  localparam int PTR_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgDmaEn,
  input  logic              cfgAckSel,
  input  logic              cfgReqInv,
  input  logic              cfgAckInv,
  input  logic              cfgBusWide,
  input  logic              gapWr,
  input  logic [GAP_W-1:0]  gapWrData,
  input  logic              pktLoad,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostAck,
  output logic              dmaReq,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [PTR_W-1:0]  srcAddr,
  input  logic [DATA_W-1:0] srcData
);

  ctrl_strb_t strb;
  logic ptrLast;
  logic ptrEnd;
  logic gapDone;
  logic reqActive;

  pkt_dma_fsm #(
    .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgDmaEn  (cfgDmaEn),
    .cfgAckSel (cfgAckSel),
    .cfgAckInv (cfgAckInv),
    .cfgBusWide(cfgBusWide),
    .pktLoad   (pktLoad),
    .hostCsN   (hostCsN),
    .hostRdN   (hostRdN),
    .hostAddr  (hostAddr),
    .hostAck   (hostAck),
    .ptrLast   (ptrLast),
    .ptrEnd    (ptrEnd),
    .gapDone   (gapDone),
    .strb      (strb),
    .reqActive (reqActive),
    .busDrive  (dataOe)
  );

  pkt_dma_path #(
    .PKT_BYTES(PKT_BYTES),
    .GAP_W    (GAP_W),
    .GAP_RESET(GAP_RESET),
    .DATA_W   (DATA_W)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .gapWr    (gapWr),
    .gapWrData(gapWrData),
    .srcData  (srcData),
    .srcAddr  (srcAddr),
    .dataOut  (dataOut),
    .ptrLast  (ptrLast),
    .ptrEnd   (ptrEnd),
    .gapDone  (gapDone)
  );

  // pin level: active low unless inverted
  assign dmaReq = ~reqActive ^ cfgReqInv;

endmodule

// File: rtl/pkt_dma_chk.sv
module pkt_dma_chk #(
  parameter int PKT_BYTES = 22,
  parameter int DATA_W    = 8,
  localparam int PTR_W    = $clog2(PKT_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgDmaEn,
  input logic              cfgBusWide,
  input logic              cfgReqInv,
  input logic              pktLoad,
  input logic              dmaReq,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic [PTR_W-1:0]  srcAddr
);

  logic reqSeen;
  assign reqSeen = (dmaReq == cfgReqInv);

  // R2: no request without DMA mode
  p_req_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reqSeen |-> cfgDmaEn);

  // R9: wide bus setting blocks requests
  p_no_req_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqSeen |-> !cfgBusWide);

  // R3: request withdrawn while the byte is on the bus
  p_no_req_on_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> !reqSeen);

  // R3: driven byte stays stable during the access
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R5: the request is off in the first cycle after release
  p_gap_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dataOe) |-> !reqSeen);

  // R8: exhausted packet never requests
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srcAddr == PTR_W'(PKT_BYTES)) |-> !reqSeen);

  // R8: a packet load restarts the pointer
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pktLoad |=> (srcAddr == '0));

  // R8: pointer never runs past the packet
  p_ptr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srcAddr <= PTR_W'(PKT_BYTES));

endmodule

bind pkt_dma_ctrl pkt_dma_chk #(
  .PKT_BYTES(PKT_BYTES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgDmaEn  (cfgDmaEn),
  .cfgBusWide(cfgBusWide),
  .cfgReqInv (cfgReqInv),
  .pktLoad   (pktLoad),
  .dmaReq    (dmaReq),
  .dataOe    (dataOe),
  .dataOut   (dataOut),
  .srcAddr   (srcAddr)
);

// File: tb/test_pkt_dma_ctrl.sv
module test_pkt_dma_ctrl;

  localparam int NB = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgDmaEn = 1'b0, cfgAckSel = 1'b0, cfgReqInv = 1'b0;
  logic       cfgAckInv = 1'b0, cfgBusWide = 1'b0;
  logic       gapWr = 1'b0;
  logic [7:0] gapWrData = '0;
  logic       pktLoad = 1'b0;
  logic       hostCsN = 1'b1, hostRdN = 1'b1, hostAck = 1'b1;
  logic [3:0] hostAddr = '0;
  logic       dmaReq, dataOe;
  logic [7:0] dataOut, srcData;
  logic [4:0] srcAddr;

  int nChk = 0;
  int nFail = 0;
  int expIdx = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] srcByte(input int i);
    return 8'(8'h5A + i * 13);
  endfunction

  assign srcData = srcByte(int'(srcAddr));

  pkt_dma_ctrl i_pkt_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgDmaEn(cfgDmaEn), .cfgAckSel(cfgAckSel),
    .cfgReqInv(cfgReqInv), .cfgAckInv(cfgAckInv), .cfgBusWide(cfgBusWide),
    .gapWr(gapWr), .gapWrData(gapWrData), .pktLoad(pktLoad),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostAddr(hostAddr),
    .hostAck(hostAck), .dmaReq(dmaReq), .dataOut(dataOut), .dataOe(dataOe),
    .srcAddr(srcAddr), .srcData(srcData)
  );

  function automatic bit reqAct();
    return dmaReq == cfgReqInv;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitReq(input string tag);
    int n = 0;
    while (!reqAct() && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " request seen"}, int'(reqAct()), 1);
  endtask

  // one DMA byte, strobe driven at a negedge, released one cycle later
  task automatic hostXfer(input bit useAck, input string tag);
    waitReq(tag);
    if (useAck) hostAck = cfgAckInv;
    else begin hostCsN = 1'b0; hostRdN = 1'b0; hostAddr = '0; end
    @(negedge clk);
    chk({tag, " dataOe"}, int'(dataOe), 1);
    chk({tag, " dataOut"}, int'(dataOut), int'(srcByte(expIdx)));
    chk({tag, " req withdrawn"}, int'(reqAct()), 0);
    if (useAck) hostAck = ~cfgAckInv;
    else begin hostCsN = 1'b1; hostRdN = 1'b1; end
    expIdx++;
  endtask

  task automatic measureGap(input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    while (!reqAct() && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk(tag, n, exp);
    chk({tag, " pointer"}, int'(srcAddr), expIdx);
  endtask

  task automatic setGap(input int g);
    gapWrData = 8'(g); gapWr = 1'b1;
    @(negedge clk);
    gapWr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req pin idle high", int'(dmaReq), 1);
    chk("R1 dataOe", int'(dataOe), 0);
    chk("R1 srcAddr", int'(srcAddr), 0);
  endtask

  task automatic t_reg_mode();
    hostAddr = 4'd3; hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 nonzero address ignored", int'(dataOe), 0);
    hostCsN = 1'b1; hostRdN = 1'b1; hostAddr = '0;
    @(negedge clk);
    chk("R10 pointer kept", int'(srcAddr), 0);
    hostCsN = 1'b0; hostRdN = 1'b0;
    @(negedge clk);
    chk("R10 register read oe", int'(dataOe), 1);
    chk("R10 register read data", int'(dataOut), int'(srcByte(0)));
    chk("R2 no request when disabled", int'(reqAct()), 0);
    hostCsN = 1'b1; hostRdN = 1'b1;
    @(negedge clk);
    expIdx = 1;
    chk("R10 pointer advanced", int'(srcAddr), 1);
  endtask

  task automatic t_gaps();
    cfgDmaEn = 1'b1;
    hostXfer(1'b0, "R3 read strobe byte");
    measureGap(4, "R6 R5 reset gap of 4");
    setGap(7);
    hostXfer(1'b0, "R3 second byte");
    measureGap(7, "R6 R5 gap of 7");
    setGap(0);
    hostXfer(1'b0, "R3 third byte");
    measureGap(1, "R5 gap of 0 acts as 1");
  endtask

  task automatic t_ack_mode();
    cfgAckSel = 1'b1;
    waitReq("R4");
    hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 read strobe ignored oe", int'(dataOe), 0);
    chk("R4 read strobe ignored req", int'(reqAct()), 1);
    hostCsN = 1'b1; hostRdN = 1'b1;
    hostXfer(1'b1, "R4 acknowledge byte");
    measureGap(1, "R4 gap after acknowledge");
    cfgReqInv = 1'b1; cfgAckInv = 1'b1; hostAck = 1'b0;
    #1;
    chk("R7 inverted request pin high", int'(dmaReq), 1);
    @(negedge clk);
    chk("R11 low ack inactive when inverted", int'(dataOe), 0);
    hostXfer(1'b1, "R11 active-high acknowledge");
    measureGap(1, "R7 gap with inverted pins");
    cfgReqInv = 1'b0; cfgAckInv = 1'b0; hostAck = 1'b1; cfgAckSel = 1'b0;
    #1;
    chk("R7 request pin active low", int'(dmaReq), 0);
  endtask

  task automatic t_disable();
    waitReq("R2");
    cfgDmaEn = 1'b0;
    #1;
    chk("R2 request drops at once", int'(reqAct()), 0);
    @(negedge clk);
    chk("R2 pointer kept", int'(srcAddr), expIdx);
    hostCsN = 1'b0; hostRdN = 1'b0;
    @(negedge clk);
    chk("R10 continue in register mode", int'(dataOut), int'(srcByte(expIdx)));
    hostCsN = 1'b1; hostRdN = 1'b1;
    @(negedge clk);
    expIdx++;
    chk("R10 pointer after register read", int'(srcAddr), expIdx);
  endtask

  task automatic t_wide();
    int seen = 0;
    cfgBusWide = 1'b1; cfgDmaEn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (reqAct()) seen++;
    end
    chk("R9 no request with wide bus", seen, 0);
    cfgBusWide = 1'b0;
  endtask

  task automatic t_full();
    int seen = 0;
    while (expIdx < NB) hostXfer(1'b0, "R8 packet byte");
    @(negedge clk);
    chk("R8 pointer at end", int'(srcAddr), NB);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (reqAct()) seen++;
    end
    chk("R8 silent after last byte", seen, 0);
    pktLoad = 1'b1;
    @(negedge clk);
    pktLoad = 1'b0;
    expIdx = 0;
    chk("R8 load clears pointer", int'(srcAddr), 0);
    hostXfer(1'b0, "R8 first byte of new packet");
    hostXfer(1'b0, "R8 second byte of new packet");
    waitReq("R8 mid");
    pktLoad = 1'b1;
    @(negedge clk);
    pktLoad = 1'b0;
    expIdx = 0;
    chk("R8 mid-packet load clears pointer", int'(srcAddr), 0);
    hostXfer(1'b0, "R8 restart byte");
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_mode();
    t_gaps();
    t_ack_mode();
    t_disable();
    t_wide();
    t_full();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule